// File: doc/BRIEF.md
# Transmit Driver Safety Guard

This block sits between a transceiver's synchronised transmit-data input and the enable of its bus driver. A low level on the transmit input asks for a dominant bit on the bus. The guard passes that request on to the driver only while no fault is active and the current operating mode allows transmission.

It watches for two faults. The first is a transmit input held low for too long, which would otherwise block the bus with a permanent dominant level. The second is an overtemperature flag from an external sensor. Each fault drops the drive request at once and is reported on its own status output.

Recovery always needs the transmit input to go high again. After a dominant timeout, the input must stay high for a minimum number of consecutive cycles before the fault clears. After a thermal shutdown, the fault clears once the temperature flag is low and the input is high in the same cycle. Both time limits are given in clock cycles.

Top module: `tx_dom_guard`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `drive_dom`, `timeout_flag` and `thermal_flag` are all 0.
- R2: With no fault active and `mode_ok` = 1, `drive_dom` equals the inverse of the `tx_pin` value sampled at the previous rising edge (pin 0 = dominant request, `drive_dom` 1 = drive dominant).
- R3: When `mode_ok` was 0 at a sampling edge, `drive_dom` is 0 after that edge, whatever `tx_pin` is.
- R4: When `tx_pin` has been sampled low on `DOM_CYC` consecutive edges, `timeout_flag` rises at the last of those edges and `drive_dom` is 0 from that same edge.
- R5: A single high sample of `tx_pin` before `DOM_CYC` consecutive lows restarts the low count, so no timeout occurs.
- R6: `timeout_flag` stays set while `tx_pin` is low. It clears at the edge where `tx_pin` has been sampled high on `REC_CYC` consecutive edges, and `drive_dom` stays 0 until then.
- R7: A low sample of `tx_pin` during timeout recovery restarts the recovery count from zero.
- R8: A high `over_temp` sampled at an edge sets `thermal_flag` after that edge, and `drive_dom` is 0.
- R9: `thermal_flag` clears only at an edge where `over_temp` is 0 and `tx_pin` is 1. It stays set while `tx_pin` is low, even after `over_temp` has cleared.
- R10: The two faults are independent, and `drive_dom` is never 1 while either status flag is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_pin | input | 1 | Synchronised transmit input, 0 = dominant request |
| over_temp | input | 1 | Overtemperature flag from the sensor |
| mode_ok | input | 1 | 1 when the operating mode allows transmission |
| drive_dom | output | 1 | Registered drive-dominant enable to the bus driver |
| timeout_flag | output | 1 | Dominant timeout fault active |
| thermal_flag | output | 1 | Thermal shutdown fault active |

## Verification
The bench builds the guard with `DOM_CYC` = 12 and `REC_CYC` = 5 in place of the microsecond-scale defaults. With these values, a full timeout, an interrupted recovery and a completed recovery each fit in a few dozen cycles. Random runs of low and high levels, whose lengths straddle both limits, can then hit the exact boundary cycles many times. Directed sequences pin down the cycles one before and exactly at each limit, as well as the thermal release that waits on the pin.

// File: rtl/txg_pkg.sv
package txg_pkg;

  typedef struct packed {
    logic timeout;
    logic thermal;
  } fault_t;

  function automatic int cnt_w(input int lim);
    return (lim < 2) ? 1 : $clog2(lim + 1);
  endfunction

endpackage

// File: rtl/txg_run_cnt.sv
module txg_run_cnt #(
  parameter int LIMIT = 4,
  parameter int W     = txg_pkg::cnt_w(LIMIT)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] LIM_V = W'(LIMIT);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (cnt != LIM_V) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/txg_dom_timeout.sv
module txg_dom_timeout #(
  parameter int DOM_CYC = 16,
  parameter int REC_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic tx_pin,
  output logic flag_q,
  output logic flag_d
);
  localparam int DW = txg_pkg::cnt_w(DOM_CYC);
  localparam int RW = txg_pkg::cnt_w(REC_CYC);
  localparam logic [DW-1:0] DOM_LAST = DW'(DOM_CYC - 1);
  localparam logic [RW-1:0] REC_LAST = RW'(REC_CYC - 1);

  logic [DW-1:0] low_cnt;
  logic [RW-1:0] rec_cnt;
  logic          low_clr;
  logic          rec_clr;

  // Next fault state: set on the last allowed low sample, clear on the last recovery high.
  always_comb begin
    if (flag_q) begin
      flag_d = !(tx_pin && (rec_cnt == REC_LAST));
    end else begin
      flag_d = !tx_pin && (low_cnt == DOM_LAST);
    end
  end

  assign low_clr = tx_pin || flag_q || flag_d;
  assign rec_clr = !tx_pin || !flag_d;

  txg_run_cnt #(.LIMIT(DOM_CYC), .W(DW)) low_run_i (
    .clk (clk),
    .rst (rst),
    .clr (low_clr),
    .cnt (low_cnt)
  );

  txg_run_cnt #(.LIMIT(REC_CYC), .W(RW)) rec_run_i (
    .clk (clk),
    .rst (rst),
    .clr (rec_clr),
    .cnt (rec_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
    end
  end
endmodule

// File: rtl/txg_thermal_hold.sv
module txg_thermal_hold (
  input  logic clk,
  input  logic rst,
  input  logic tx_pin,
  input  logic over_temp,
  output logic flag_q,
  output logic flag_d
);
  // Set while hot; released only when cool and the pin is back high.
  always_comb begin
    if (over_temp) begin
      flag_d = 1'b1;
    end else if (flag_q) begin
      flag_d = !tx_pin;
    end else begin
      flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
    end
  end
endmodule

// File: rtl/tx_dom_guard.sv
module tx_dom_guard #(
  parameter int DOM_CYC = 50000,
  parameter int REC_CYC = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic tx_pin,
  input  logic over_temp,
  input  logic mode_ok,
  output logic drive_dom,
  output logic timeout_flag,
  output logic thermal_flag
);
  import txg_pkg::*;

  fault_t flt_q;
  fault_t flt_d;
  logic   drive_q;

  txg_dom_timeout #(.DOM_CYC(DOM_CYC), .REC_CYC(REC_CYC)) dom_i (
    .clk    (clk),
    .rst    (rst),
    .tx_pin (tx_pin),
    .flag_q (flt_q.timeout),
    .flag_d (flt_d.timeout)
  );

  txg_thermal_hold therm_i (
    .clk       (clk),
    .rst       (rst),
    .tx_pin    (tx_pin),
    .over_temp (over_temp),
    .flag_q    (flt_q.thermal),
    .flag_d    (flt_d.thermal)
  );

  // Drive decision uses the next fault state so a new fault gates the same edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      drive_q <= 1'b0;
    end else begin
      drive_q <= !tx_pin && mode_ok && (flt_d == '0);
    end
  end

  assign drive_dom    = drive_q;
  assign timeout_flag = flt_q.timeout;
  assign thermal_flag = flt_q.thermal;
endmodule

// File: rtl/tx_dom_guard_chk.sv
module tx_dom_guard_chk #(
  parameter int DOM_CYC = 50000,
  parameter int REC_CYC = 200
) (
  input logic clk,
  input logic rst,
  input logic tx_pin,
  input logic over_temp,
  input logic mode_ok,
  input logic drive_dom,
  input logic timeout_flag,
  input logic thermal_flag
);
  logic [31:0] lo_run;
  logic [31:0] hi_run;
  logic        past_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_run  <= '0;
      hi_run  <= '0;
      past_ok <= 1'b0;
    end else begin
      past_ok <= 1'b1;
      lo_run  <= tx_pin ? '0 : ((lo_run == '1) ? lo_run : lo_run + 1);
      hi_run  <= !tx_pin ? '0 : ((hi_run == '1) ? hi_run : hi_run + 1);
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> !drive_dom && !timeout_flag && !thermal_flag);

  assert_drive_from_pin_R2: assert property (@(posedge clk) disable iff (rst)
    past_ok && drive_dom |-> !$past(tx_pin));

  assert_mode_gate_R3: assert property (@(posedge clk) disable iff (rst)
    past_ok && drive_dom |-> $past(mode_ok));

  assert_timeout_window_R4: assert property (@(posedge clk) disable iff (rst)
    past_ok && $rose(timeout_flag) |-> (lo_run >= 32'(DOM_CYC)));

  assert_recover_window_R6: assert property (@(posedge clk) disable iff (rst)
    past_ok && $fell(timeout_flag) |-> (hi_run >= 32'(REC_CYC)));

  assert_thermal_set_R8: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(over_temp) |-> thermal_flag);

  assert_thermal_release_R9: assert property (@(posedge clk) disable iff (rst)
    past_ok && $fell(thermal_flag) |-> $past(tx_pin) && !$past(over_temp));

  assert_no_drive_in_fault_R10: assert property (@(posedge clk) disable iff (rst)
    drive_dom |-> !timeout_flag && !thermal_flag);
endmodule

bind tx_dom_guard tx_dom_guard_chk #(.DOM_CYC(DOM_CYC), .REC_CYC(REC_CYC)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .tx_pin       (tx_pin),
  .over_temp    (over_temp),
  .mode_ok      (mode_ok),
  .drive_dom    (drive_dom),
  .timeout_flag (timeout_flag),
  .thermal_flag (thermal_flag)
);

// File: tb/tx_dom_guard_tb_top.sv
module tx_dom_guard_tb_top;
  localparam int DOM = 12;
  localparam int REC = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx_pin = 1'b1;
  logic over_temp = 1'b0;
  logic mode_ok = 1'b1;
  logic drive_dom, timeout_flag, thermal_flag;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // reference model state (value after the most recent edge)
  int m_lo = 0;
  int m_hi = 0;
  bit m_to = 1'b0;
  bit m_th = 1'b0;
  bit m_drv = 1'b0;

  always #10 clk = ~clk;

  tx_dom_guard #(.DOM_CYC(DOM), .REC_CYC(REC)) dut_i (
    .clk          (clk),
    .rst          (rst),
    .tx_pin       (tx_pin),
    .over_temp    (over_temp),
    .mode_ok      (mode_ok),
    .drive_dom    (drive_dom),
    .timeout_flag (timeout_flag),
    .thermal_flag (thermal_flag)
  );

  function automatic bit next_to(bit to, int lo, int hi);
    if (!to) return (lo >= DOM);
    return !(hi >= REC);
  endfunction

  function automatic bit next_th(bit th, bit ot, bit tx);
    if (ot) return 1'b1;
    if (th) return !tx;
    return 1'b0;
  endfunction

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Called at a falling edge: drive inputs, advance model, check after the next rising edge.
  task automatic step(input bit tx, input bit ot, input bit ok, input string tag);
    tx_pin = tx;
    over_temp = ot;
    mode_ok = ok;
    m_lo = tx ? 0 : m_lo + 1;
    m_hi = tx ? m_hi + 1 : 0;
    m_to = next_to(m_to, m_lo, m_hi);
    m_th = next_th(m_th, ot, tx);
    m_drv = !tx && ok && !m_to && !m_th;
    @(negedge clk);
    chk(tag, "drive_dom", drive_dom, m_drv);
    chk(tag, "timeout_flag", timeout_flag, m_to);
    chk(tag, "thermal_flag", thermal_flag, m_th);
  endtask

  task automatic run(input bit tx, input int len, input bit ot, input bit ok, input string tag);
    for (int i = 0; i < len; i++) step(tx, ot, ok, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    tx_pin = 1'b0;
    over_temp = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset holds outputs low even with faulty inputs
    chk("R1", "drive_dom", drive_dom, 1'b0);
    chk("R1", "timeout_flag", timeout_flag, 1'b0);
    chk("R1", "thermal_flag", thermal_flag, 1'b0);
    rst = 1'b0;
    step(1'b1, 1'b0, 1'b1, "R1");

    // R2: plain pass-through
    step(1'b0, 1'b0, 1'b1, "R2");
    step(1'b1, 1'b0, 1'b1, "R2");
    step(1'b0, 1'b0, 1'b1, "R2");
    step(1'b0, 1'b0, 1'b1, "R2");
    step(1'b1, 1'b0, 1'b1, "R2");

    // R3: mode blocks transmission
    run(1'b0, 3, 1'b0, 1'b0, "R3");
    step(1'b1, 1'b0, 1'b0, "R3");

    // R5: one short of the limit, a high, one short again
    run(1'b0, DOM - 1, 1'b0, 1'b1, "R5");
    step(1'b1, 1'b0, 1'b1, "R5");
    run(1'b0, DOM - 1, 1'b0, 1'b1, "R5");
    chk("R5", "no timeout", timeout_flag, 1'b0);
    step(1'b1, 1'b0, 1'b1, "R5");

    // R4: exactly the limit
    run(1'b0, DOM, 1'b0, 1'b1, "R4");
    chk("R4", "timeout at limit", timeout_flag, 1'b1);
    chk("R4", "drive off", drive_dom, 1'b0);

    // R6: held while low, then recovery
    run(1'b0, 4, 1'b0, 1'b1, "R6");
    // R7: recovery interrupted one short
    run(1'b1, REC - 1, 1'b0, 1'b1, "R7");
    step(1'b0, 1'b0, 1'b1, "R7");
    chk("R7", "still timed out", timeout_flag, 1'b1);
    run(1'b1, REC - 1, 1'b0, 1'b1, "R6");
    chk("R6", "not yet clear", timeout_flag, 1'b1);
    step(1'b1, 1'b0, 1'b1, "R6");
    chk("R6", "cleared", timeout_flag, 1'b0);
    step(1'b0, 1'b0, 1'b1, "R6");
    chk("R6", "drive resumes", drive_dom, 1'b1);
    step(1'b1, 1'b0, 1'b1, "R6");

    // R8/R9: thermal hold
    step(1'b0, 1'b1, 1'b1, "R8");
    chk("R8", "thermal set", thermal_flag, 1'b1);
    run(1'b0, 3, 1'b0, 1'b1, "R9");
    chk("R9", "held while pin low", thermal_flag, 1'b1);
    step(1'b1, 1'b1, 1'b1, "R9");
    chk("R9", "held while hot", thermal_flag, 1'b1);
    step(1'b1, 1'b0, 1'b1, "R9");
    chk("R9", "released", thermal_flag, 1'b0);

    // R10: both faults at once
    run(1'b0, DOM, 1'b1, 1'b1, "R10");
    run(1'b1, REC, 1'b1, 1'b1, "R10");
    chk("R10", "thermal outlives timeout", thermal_flag, 1'b1);
    step(1'b1, 1'b0, 1'b1, "R10");

    // R10: random runs straddling both limits
    for (int k = 0; k < 1500; k++) begin
      bit tx = ($urandom % 2) == 1;
      int len = 1 + ($urandom % (DOM + 4));
      bit ot = ($urandom % 20) == 0;
      bit ok = ($urandom % 10) != 0;
      run(tx, len, ot, ok, "R10");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule